// File: doc/BRIEF.md
# Shared-Unit Two-Expression Datapath

This block evaluates two arithmetic results from five unsigned operands: X = W + S·T and Y = S·T + U·V. It has exactly one multiplier and one adder. Operand multiplexers in front of each unit choose its inputs, and a small step controller moves the work through three fixed control steps. The product S·T is needed by both results. It is formed once, held in a temporary register, and read by both additions.

A caller presents the five operands with a start pulse while the block is idle. The operands are copied into internal registers on that clock edge, so the caller may change its inputs at once. A one-cycle done pulse follows. X and Y then stay valid until a later operation overwrites them. A start that arrives while an operation is in flight is ignored.

Top module: `cse_sched_dp`

## Requirements
- R1: While reset (rst_n low) is applied and in the first cycle after it, x_out and y_out are 0 and done is 0.
- R2: After an operation, x_out equals w + s·t, with all operands unsigned OPW-bit values and a 2·OPW+1 bit result. Example: all operands 255 gives 65280.
- R3: After an operation, y_out equals s·t + u·v as an unsigned 2·OPW+1 bit value. Example: all operands 255 gives 130050.
- R4: If start is sampled high at an idle clock edge, done is high for exactly the one cycle that follows the third later edge. It is low in every other cycle of the operation.
- R5: Operands are taken only at the edge where start is accepted. Input changes after that edge do not change that operation's x_out or y_out.
- R6: While an operation is in flight, start is ignored. Holding start high does not restart the sequence, does not move the done pulse and does not alter the results.
- R7: While the block is idle, x_out and y_out hold their last values, whatever the operand inputs do.
- R8: A new start is accepted at the first edge after the done cycle. Back-to-back operations therefore complete every 5 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; accepted only when idle |
| w_in | input | OPW | Addend of X |
| s_in | input | OPW | First factor of the shared product |
| t_in | input | OPW | Second factor of the shared product |
| u_in | input | OPW | First factor of the second product |
| v_in | input | OPW | Second factor of the second product |
| x_out | output | 2*OPW+1 | Result W + S·T |
| y_out | output | 2*OPW+1 | Result S·T + U·V |
| done | output | 1 | One-cycle pulse when both results are valid |

## Verification
Suppose the step state advanced wrongly or a load enable fired in the wrong step. The done pulse would then appear in a different cycle within four cycles of start, or X and Y would pick up a wrong operand pair. Both show up at the first done pulse. A temporary register that was read stale, or overwritten, would make X and Y disagree about S·T. The sweep catches this because the expected X and Y are recomputed for every operand set. The operands and start are also scrambled during the operation, so a capture register that keeps following its input shows up at once.

// File: rtl/cse_sched_pkg.sv
package cse_sched_pkg;
  // control steps of the fixed schedule
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MUL1 = 3'd1,   // shared product into temp
    ST_MIX2 = 3'd2,   // second product, X addition
    ST_ADD3 = 3'd3,   // Y addition
    ST_FIN  = 3'd4    // results valid, done high
  } step_e;

  // multiplier operand choice
  typedef enum logic {
    MSEL_ST = 1'b0,
    MSEL_UV = 1'b1
  } mul_sel_e;

  // adder operand choice
  typedef enum logic {
    ASEL_X = 1'b0,
    ASEL_Y = 1'b1
  } add_sel_e;
endpackage

// File: rtl/cse_sched_ctrl.sv
module cse_sched_ctrl
  import cse_sched_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output step_e    step,
  output logic     capture,
  output logic     ld_temp,
  output logic     ld_uv,
  output logic     ld_x,
  output logic     ld_y,
  output mul_sel_e mul_sel,
  output add_sel_e add_sel,
  output logic     done
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE: if (start) step_d = ST_MUL1;
      ST_MUL1: step_d = ST_MIX2;
      ST_MIX2: step_d = ST_ADD3;
      ST_ADD3: step_d = ST_FIN;
      ST_FIN:  step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  assign step    = step_q;
  assign capture = (step_q == ST_IDLE) && start;
  assign ld_temp = (step_q == ST_MUL1);
  assign ld_uv   = (step_q == ST_MIX2);
  assign ld_x    = (step_q == ST_MIX2);
  assign ld_y    = (step_q == ST_ADD3);
  assign mul_sel = (step_q == ST_MIX2) ? MSEL_UV : MSEL_ST;
  assign add_sel = (step_q == ST_ADD3) ? ASEL_Y : ASEL_X;
  assign done    = (step_q == ST_FIN);
endmodule

// File: rtl/cse_mul_unit.sv
module cse_mul_unit
  import cse_sched_pkg::*;
#(
  parameter int OPW = 8,
  localparam int PW = 2 * OPW
) (
  input  mul_sel_e       sel,
  input  logic [OPW-1:0] s_op,
  input  logic [OPW-1:0] t_op,
  input  logic [OPW-1:0] u_op,
  input  logic [OPW-1:0] v_op,
  output logic [PW-1:0]  prod
);
  function automatic logic [PW-1:0] umul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  logic [OPW-1:0] a_mux, b_mux;

  always_comb begin
    a_mux = (sel == MSEL_UV) ? u_op : s_op;
    b_mux = (sel == MSEL_UV) ? v_op : t_op;
  end

  assign prod = umul(a_mux, b_mux);
endmodule

// File: rtl/cse_add_unit.sv
module cse_add_unit
  import cse_sched_pkg::*;
#(
  parameter int OPW = 8,
  localparam int PW = 2 * OPW,
  localparam int SW = PW + 1
) (
  input  add_sel_e       sel,
  input  logic [OPW-1:0] w_op,
  input  logic [PW-1:0]  temp,
  input  logic [PW-1:0]  uv,
  output logic [SW-1:0]  sum
);
  function automatic logic [SW-1:0] uadd(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return SW'(a) + SW'(b);
  endfunction

  logic [PW-1:0] a_mux;

  // temp is always one addend; the other is W (for X) or U*V (for Y)
  assign a_mux = (sel == ASEL_Y) ? uv : PW'(w_op);
  assign sum   = uadd(temp, a_mux);
endmodule

// File: rtl/cse_sched_dp.sv
module cse_sched_dp
  import cse_sched_pkg::*;
#(
  parameter int OPW = 8,
  localparam int PW = 2 * OPW,
  localparam int SW = PW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] w_in,
  input  logic [OPW-1:0] s_in,
  input  logic [OPW-1:0] t_in,
  input  logic [OPW-1:0] u_in,
  input  logic [OPW-1:0] v_in,
  output logic [SW-1:0]  x_out,
  output logic [SW-1:0]  y_out,
  output logic           done
);
  step_e    step;
  logic     capture, ld_temp, ld_uv, ld_x, ld_y;
  mul_sel_e mul_sel;
  add_sel_e add_sel;

  logic [OPW-1:0] w_q, s_q, t_q, u_q, v_q;
  logic [PW-1:0]  temp_q, uv_q, prod;
  logic [SW-1:0]  sum;

  cse_sched_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (step),
    .capture (capture),
    .ld_temp (ld_temp),
    .ld_uv   (ld_uv),
    .ld_x    (ld_x),
    .ld_y    (ld_y),
    .mul_sel (mul_sel),
    .add_sel (add_sel),
    .done    (done)
  );

  cse_mul_unit #(.OPW(OPW)) mul_i (
    .sel  (mul_sel),
    .s_op (s_q),
    .t_op (t_q),
    .u_op (u_q),
    .v_op (v_q),
    .prod (prod)
  );

  cse_add_unit #(.OPW(OPW)) add_i (
    .sel  (add_sel),
    .w_op (w_q),
    .temp (temp_q),
    .uv   (uv_q),
    .sum  (sum)
  );

  // operand capture on accepted start only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0; s_q <= '0; t_q <= '0; u_q <= '0; v_q <= '0;
    end else if (capture) begin
      w_q <= w_in; s_q <= s_in; t_q <= t_in; u_q <= u_in; v_q <= v_in;
    end
  end

  // product registers: shared S*T and step-2 U*V
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      uv_q   <= '0;
    end else begin
      if (ld_temp) temp_q <= prod;
      if (ld_uv)   uv_q   <= prod;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_out <= '0;
      y_out <= '0;
    end else begin
      if (ld_x) x_out <= sum;
      if (ld_y) y_out <= sum;
    end
  end
endmodule

// File: rtl/cse_sched_dp_chk.sv
module cse_sched_dp_chk
  import cse_sched_pkg::*;
#(
  parameter int OPW = 8,
  localparam int SW = 2 * OPW + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input step_e          step,
  input logic [SW-1:0]  x_out,
  input logic [SW-1:0]  y_out,
  input logic [OPW-1:0] w_q,
  input logic [OPW-1:0] s_q,
  input logic [OPW-1:0] t_q,
  input logic [OPW-1:0] u_q,
  input logic [OPW-1:0] v_q
);
  logic [5*OPW-1:0] ops;
  assign ops = {w_q, s_q, t_q, u_q, v_q};

  // R4
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_after_step3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_ADD3) |=> done);

  // R6
  start_from_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_MUL1) |-> ($past(step) == ST_IDLE));

  // R7
  idle_results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_IDLE) |=> ($stable(x_out) && $stable(y_out)));

  // R5
  operands_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_IDLE) |=> $stable(ops));

  // R2
  x_moves_in_step2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(x_out) |-> ($past(step) == ST_MIX2));

  // R3
  y_moves_in_step3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_out) |-> ($past(step) == ST_ADD3));
endmodule

bind cse_sched_dp cse_sched_dp_chk #(.OPW(OPW)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .done  (done),
  .step  (step),
  .x_out (x_out),
  .y_out (y_out),
  .w_q   (w_q),
  .s_q   (s_q),
  .t_q   (t_q),
  .u_q   (u_q),
  .v_q   (v_q)
);

// File: tb/cse_sched_dp_tb.sv
module cse_sched_dp_tb_top;
  localparam int OPW = 8;
  localparam int SW  = 2 * OPW + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [OPW-1:0] w_in = '0, s_in = '0, t_in = '0, u_in = '0, v_in = '0;
  logic [SW-1:0]  x_out, y_out;
  logic           done;

  int checks = 0;
  int fails  = 0;

  cse_sched_dp #(.OPW(OPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .w_in(w_in), .s_in(s_in), .t_in(t_in), .u_in(u_in), .v_in(v_in),
    .x_out(x_out), .y_out(y_out), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one operation; called at a negedge, returns at the negedge after done
  task automatic run_op(input int w, input int s, input int t, input int u, input int v);
    longint xe, ye;
    xe = longint'(w) + longint'(s) * longint'(t);
    ye = longint'(s) * longint'(t) + longint'(u) * longint'(v);
    w_in = OPW'(w); s_in = OPW'(s); t_in = OPW'(t); u_in = OPW'(u); v_in = OPW'(v);
    start = 1'b1;
    @(negedge clk);                        // start sampled (edge 0)
    // R5 / R6: scramble operands and keep start high while busy
    w_in = ~w_in; s_in = ~s_in; t_in = ~t_in; u_in = ~u_in; v_in = ~v_in;
    chk("R4 done low step1", done, 0);
    @(negedge clk);
    chk("R4 done low step2", done, 0);
    @(negedge clk);
    chk("R4 done low step3", done, 0);
    @(negedge clk);
    chk("R4 done pulse", done, 1);
    chk("R2 x result", x_out, xe);
    chk("R3 y result", y_out, ye);
    start = 1'b0;
    @(negedge clk);
    chk("R4 done single cycle", done, 0);
    chk("R7 x held", x_out, xe);
    chk("R7 y held", y_out, ye);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int vals [7];
    logic [SW-1:0] xh, yh;
    vals = '{0, 1, 2, 127, 128, 254, 255};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 x reset", x_out, 0);
    chk("R1 y reset", y_out, 0);
    chk("R1 done reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 x after reset", x_out, 0);
    chk("R1 done after reset", done, 0);

    // R2 R3 corner: all maximum
    run_op(255, 255, 255, 255, 255);
    chk("R2 max x", x_out, 65280);
    chk("R3 max y", y_out, 130050);

    // R8: back-to-back ops, each started at the negedge run_op returns on
    foreach (vals[a]) foreach (vals[b]) foreach (vals[c]) foreach (vals[d]) foreach (vals[e])
      run_op(vals[a], vals[b], vals[c], vals[d], vals[e]);

    // R8 explicit: next op accepted right after done, done 4 cycles later
    run_op(3, 5, 7, 11, 13);
    run_op(200, 9, 17, 33, 65);
    chk("R8 second back-to-back x", x_out, 200 + 9 * 17);

    // R7 idle: operands wander, no start, results unchanged
    xh = x_out; yh = y_out;
    for (int i = 0; i < 10; i++) begin
      w_in = OPW'(i * 37); s_in = OPW'(i * 11); t_in = OPW'(i * 5);
      u_in = OPW'(i * 3); v_in = OPW'(i * 29);
      @(negedge clk);
      chk("R7 idle x stable", x_out, xh);
      chk("R7 idle y stable", y_out, yh);
      chk("R7 idle done low", done, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule